// File: doc/BRIEF.md
# Two-Word Pixel Bus Unpacker

This block sits behind a narrow pixel input port where every pixel crosses the bus as two successive words, a first half and a second half. It counts bus words from each horizontal-sync start, throws away a programmable number of lead-in words, and then pairs the remaining words. Each pair is rebuilt into one parallel pixel according to the format chosen for the line.

Four RGB packings are handled. Two of them are 16-bit packings on the low 8 bus bits: 5-6-5 and 5-5-5. The other two are 8-8-8 arrangements spread over two 12-bit words. A YCrCb byte stream (Cb, Y0, Cr, Y1 ...) is also handled. Here each pair gives one luma sample and the chroma byte it shares, together with a flag that says whether that byte is Cb or Cr. Colour fields narrower than 8 bits are widened by copying their upper bits into the vacated low bits. The format and the lead-in count are sampled only at horizontal sync, so changes made part-way through a line wait for the next line.

Top module: `pxl_pair_unpack`

## Requirements
- R1: While reset is held and after it, `pix_valid` is low and `pix_c0`, `pix_c1`, `pix_c2` and `pix_is_cr` are zero. No pixel is produced before the first `hs_start` pulse, whatever `word_en` does.
- R2: The bus words that follow an `hs_start` cycle are numbered 0, 1, 2 ... A word counts only in a cycle where `word_en` is high and `hs_start` is low. Words 0 to `sav_cnt`-1 are discarded, and word number `sav_cnt` is the first half of the first pixel. `sav_cnt` is sampled in the `hs_start` cycle.
- R3: After the lead-in, the words alternate between first half and second half. `pix_valid` is high for exactly one cycle, in the cycle after the clock edge that captured a second half. Cycles with `word_en` low neither count nor change the phase.
- R4: Mode 0 (RGB 5-6-5) unpacks B[4:0]=first[4:0], G[2:0]=first[7:5], G[5:3]=second[2:0] and R[4:0]=second[7:3]. `pix_c0`/`pix_c1`/`pix_c2` carry R/G/B.
- R5: Mode 1 (RGB 5-5-5) unpacks B[4:0]=first[4:0], G[2:0]=first[7:5], G[4:3]=second[1:0] and R[4:0]=second[6:2]. second[7] is ignored.
- R6: Mode 2 (8-8-8, arrangement A) unpacks B=first[7:0], G[3:0]=first[11:8], G[7:4]=second[3:0] and R=second[11:4].
- R7: Mode 3 (8-8-8, arrangement B) unpacks B=first[7:0], G[7:4]=first[11:8], G[3:0]=second[3:0] and R=second[11:4].
- R8: Mode 4 (YCrCb) takes the chroma byte from first[7:0] and luma from second[7:0]. It outputs `pix_c0`=Y, `pix_c1`=chroma and `pix_c2`=0. `pix_is_cr` is 0 for the first pair of a line and then alternates with every pair; it is 0 in all other modes.
- R9: 5-bit fields widen as {x[4:0],x[4:2]} and 6-bit fields as {x[5:0],x[5:4]}.
- R10: `mode_sel` is sampled only in an `hs_start` cycle. A change at any other time has no effect until the next `hs_start`.
- R11: Mode codes 5, 6 and 7 produce no `pix_valid` pulse.
- R12: An `hs_start` pulse that arrives between the two halves of a pixel abandons the stored first half and restarts the word count. It produces no pixel.
- R13: In modes 0, 1 and 4, bus bits [11:8] have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_en | input | 1 | A bus word is present this cycle |
| hs_start | input | 1 | Horizontal-sync start, one cycle |
| mode_sel | input | 3 | Input format code, sampled at `hs_start` |
| sav_cnt | input | 9 | Number of lead-in words to discard, sampled at `hs_start` |
| bus_d | input | 12 | Pixel bus word |
| pix_valid | output | 1 | Rebuilt pixel present, one-cycle pulse |
| pix_c0 | output | 8 | R, or Y in YCrCb mode |
| pix_c1 | output | 8 | G, or chroma in YCrCb mode |
| pix_c2 | output | 8 | B, or zero in YCrCb mode |
| pix_is_cr | output | 1 | Chroma byte on `pix_c1` is Cr (1) or Cb (0) |

## Verification
A vector table drives every mode with field values whose bits differ between neighbouring positions, so a swapped or shifted field shows up as a wrong channel. Some values are all-ones or have only the top bit set, which separates the widening rule from zero fill. Lead-in counts of 0, small values, 11 and the 9-bit maximum test the first-half alignment, and junk in the upper bus nibble tests that the 8-bit modes ignore those bits. Directed sequences test the remaining behaviour. They insert idle gaps between halves, change the mode in the middle of a line, use a reserved code, send a sync between two halves, send words before any sync, and stream three YCrCb pairs back to back so that the Cb/Cr alternation and the spacing of the valid pulses can be seen.

// File: rtl/pxl_pkg.sv
// Shared types and helpers for the two-word pixel unpacker.
// Assumes 8-bit output channels; widening helpers build them from narrow fields.
package pxl_pkg;

    localparam int CH_W = 8;

    typedef enum logic [2:0] {
        FMT_RGB565  = 3'd0,
        FMT_RGB555  = 3'd1,
        FMT_RGB888A = 3'd2,
        FMT_RGB888B = 3'd3,
        FMT_YCC     = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] c0;
        logic [CH_W-1:0] c1;
        logic [CH_W-1:0] c2;
    } pix_t;

    // Widen a 5-bit colour field by repeating its top bits.
    function automatic logic [CH_W-1:0] widen5(input logic [4:0] f);
        return {f, f[4:2]};
    endfunction

    // Widen a 6-bit colour field by repeating its top bits.
    function automatic logic [CH_W-1:0] widen6(input logic [5:0] f);
        return {f, f[5:4]};
    endfunction

endpackage

// File: rtl/pxl_word_timer.sv
// Word phase tracker: counts bus words after horizontal sync, skips the
// lead-in, then marks each counted word as first or second half of a pixel.
// Assumes hs_start and word_en are synchronous to clk; a word in the
// hs_start cycle is not counted.
module pxl_word_timer #(
    parameter int SAV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_en,
    input  logic             hs_start,
    input  logic [SAV_W-1:0] sav_cnt,
    output logic             first_stb,
    output logic             second_stb,
    output logic             cr_phase
);

    logic             armed;
    logic [SAV_W-1:0] cnt;
    logic [SAV_W-1:0] sav_q;
    logic             half;
    logic             crph;
    logic             active;

    // Track lead-in count, half phase and chroma phase per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
            sav_q <= '0;
            half  <= 1'b0;
            crph  <= 1'b0;
        end else if (hs_start) begin
            armed <= 1'b1;
            cnt   <= '0;
            sav_q <= sav_cnt;
            half  <= 1'b0;
            crph  <= 1'b0;
        end else if (word_en && armed) begin
            if (cnt != sav_q) begin
                cnt <= cnt + 1'b1;
            end else begin
                half <= ~half;
                if (half) crph <= ~crph;
            end
        end
    end

    // Decode which half, if any, the current word is.
    always_comb begin
        active     = armed && word_en && !hs_start && (cnt == sav_q);
        first_stb  = active && !half;
        second_stb = active && half;
        cr_phase   = crph;
    end

    assert_halves_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({first_stb, second_stb}));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= sav_q);

    assert_sav_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_start |=> $stable(sav_q));

    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |=> (cnt == '0 && !half && !second_stb));

endmodule

// File: rtl/pxl_unpack.sv
// Format decoder: combines a stored first word and the current second word
// into one pixel. Pure combinational; known is low for reserved codes.
// Assumes a 12-bit bus; 16-bit RGB and YCrCb use only bits [7:0].
module pxl_unpack
    import pxl_pkg::*;
#(
    parameter int BUS_W = 12
) (
    input  logic [2:0]       fmt,
    input  logic [BUS_W-1:0] w_first,
    input  logic [BUS_W-1:0] w_second,
    output pix_t             px,
    output logic             known
);

    // Select the bit packing for the chosen format.
    always_comb begin
        px    = '0;
        known = 1'b1;
        case (fmt)
            FMT_RGB565: begin
                px.c0 = widen5(w_second[7:3]);
                px.c1 = widen6({w_second[2:0], w_first[7:5]});
                px.c2 = widen5(w_first[4:0]);
            end
            FMT_RGB555: begin
                px.c0 = widen5(w_second[6:2]);
                px.c1 = widen5({w_second[1:0], w_first[7:5]});
                px.c2 = widen5(w_first[4:0]);
            end
            FMT_RGB888A: begin
                px.c0 = w_second[11:4];
                px.c1 = {w_second[3:0], w_first[11:8]};
                px.c2 = w_first[7:0];
            end
            FMT_RGB888B: begin
                px.c0 = w_second[11:4];
                px.c1 = {w_first[11:8], w_second[3:0]};
                px.c2 = w_first[7:0];
            end
            FMT_YCC: begin
                px.c0 = w_second[7:0];
                px.c1 = w_first[7:0];
                px.c2 = '0;
            end
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/pxl_pair_unpack.sv
// Top: two-word pixel bus unpacker. Latches the format at horizontal sync,
// holds each first-half word, and registers the rebuilt pixel with a
// one-cycle valid when the second half arrives.
// Assumes the lead-in count and format are stable in the hs_start cycle.
module pxl_pair_unpack
    import pxl_pkg::*;
#(
    parameter int BUS_W = 12,
    parameter int SAV_W = 9,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_en,
    input  logic              hs_start,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [SAV_W-1:0]  sav_cnt,
    input  logic [BUS_W-1:0]  bus_d,
    output logic              pix_valid,
    output logic [CH_W-1:0]   pix_c0,
    output logic [CH_W-1:0]   pix_c1,
    output logic [CH_W-1:0]   pix_c2,
    output logic              pix_is_cr
);

    logic [MODE_W-1:0] mode_q;
    logic [BUS_W-1:0]  first_q;
    logic              first_stb;
    logic              second_stb;
    logic              cr_phase;
    pix_t              px_next;
    logic              fmt_known;

    pxl_word_timer #(.SAV_W(SAV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_en    (word_en),
        .hs_start   (hs_start),
        .sav_cnt    (sav_cnt),
        .first_stb  (first_stb),
        .second_stb (second_stb),
        .cr_phase   (cr_phase)
    );

    pxl_unpack #(.BUS_W(BUS_W)) u_unpack (
        .fmt      (mode_q),
        .w_first  (first_q),
        .w_second (bus_d),
        .px       (px_next),
        .known    (fmt_known)
    );

    // Sample the format once per line at horizontal sync.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= '0;
        else if (hs_start) mode_q <= mode_sel;
    end

    // Hold the first half of the pixel being assembled.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_q <= '0;
        else if (first_stb) first_q <= bus_d;
    end

    // Register the rebuilt pixel and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_c0    <= '0;
            pix_c1    <= '0;
            pix_c2    <= '0;
            pix_is_cr <= 1'b0;
        end else begin
            pix_valid <= second_stb && fmt_known;
            if (second_stb && fmt_known) begin
                pix_c0    <= px_next.c0;
                pix_c1    <= px_next.c1;
                pix_c2    <= px_next.c2;
                pix_is_cr <= (mode_q == FMT_YCC) ? cr_phase : 1'b0;
            end
        end
    end

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_start |=> $stable(mode_q));

    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q > 3'd4) |-> !pix_valid);

    assert_hs_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |=> !pix_valid);

endmodule

// File: tb/tb_pxl_pair_unpack.sv
// Bench: vector table of formats and field values, then directed tests.
module tb_pxl_pair_unpack;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_en = 1'b0;
    logic        hs_start = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic [8:0]  sav_cnt = '0;
    logic [11:0] bus_d = '0;
    logic        pix_valid;
    logic [7:0]  pix_c0, pix_c1, pix_c2;
    logic        pix_is_cr;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // {mode, sav, r_or_y, g, b_or_chroma}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 9'd0,   8'h1F, 8'h3F, 8'h1F},
        {3'd0, 9'd3,   8'h10, 8'h2A, 8'h05},
        {3'd1, 9'd1,   8'h15, 8'h0A, 8'h1E},
        {3'd1, 9'd0,   8'h00, 8'h1F, 8'h01},
        {3'd2, 9'd2,   8'hC3, 8'h5A, 8'h81},
        {3'd2, 9'd0,   8'h00, 8'hFF, 8'h7E},
        {3'd3, 9'd5,   8'h12, 8'h34, 8'h56},
        {3'd3, 9'd11,  8'hFE, 8'hA5, 8'h01},
        {3'd4, 9'd4,   8'hEB, 8'h00, 8'h80},
        {3'd0, 9'd511, 8'h0A, 8'h15, 8'h1B}
    };

    pxl_pair_unpack dut (
        .clk(clk), .rst_n(rst_n), .word_en(word_en), .hs_start(hs_start),
        .mode_sel(mode_sel), .sav_cnt(sav_cnt), .bus_d(bus_d),
        .pix_valid(pix_valid), .pix_c0(pix_c0), .pix_c1(pix_c1),
        .pix_c2(pix_c2), .pix_is_cr(pix_is_cr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk); word_en = 1'b0; hs_start = 1'b0;
    endtask

    task automatic hsync(input logic [2:0] m, input logic [8:0] s);
        @(negedge clk); hs_start = 1'b1; word_en = 1'b0; mode_sel = m; sav_cnt = s;
    endtask

    task automatic word(input logic [11:0] d);
        @(negedge clk); hs_start = 1'b0; word_en = 1'b1; bus_d = d;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    // Build the two bus words for a format; junk in unused upper bits.
    function automatic logic [23:0] pack(input logic [2:0] m, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        logic [11:0] w0, w1;
        case (m)
            3'd0: begin w0 = {4'hA, g[2:0], b[4:0]}; w1 = {4'h5, r[4:0], g[5:3]}; end
            3'd1: begin w0 = {4'hA, g[2:0], b[4:0]}; w1 = {4'h5, 1'b1, r[4:0], g[4:3]}; end
            3'd2: begin w0 = {g[3:0], b}; w1 = {r, g[7:4]}; end
            3'd3: begin w0 = {g[7:4], b}; w1 = {r, g[3:0]}; end
            default: begin w0 = {4'hC, b}; w1 = {4'h3, r}; end
        endcase
        return {w0, w1};
    endfunction

    function automatic logic [7:0] wid(input int v, input int bits);
        return 8'(((v << (8 - bits)) | (v >> (2 * bits - 8))) & 255);
    endfunction

    // Expected {c0,c1,c2} from the requirements.
    function automatic logic [23:0] expect_px(input logic [2:0] m, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        case (m)
            3'd0: return {wid(int'(r) & 31, 5), wid(int'(g) & 63, 6), wid(int'(b) & 31, 5)};
            3'd1: return {wid(int'(r) & 31, 5), wid(int'(g) & 31, 5), wid(int'(b) & 31, 5)};
            3'd2, 3'd3: return {r, g, b};
            default: return {r, b, 8'h00};
        endcase
    endfunction

    function automatic string mtag(input logic [2:0] m);
        case (m)
            3'd0: return "R4/R9/R13";
            3'd1: return "R5/R9/R13";
            3'd2: return "R6";
            3'd3: return "R7";
            default: return "R8/R13";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        logic [23:0] e;
        bit seen;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(!pix_valid && {pix_c0, pix_c1, pix_c2} == 0 && !pix_is_cr, "R1 reset outputs",
            {7'd0, pix_valid, pix_c0, pix_c1, pix_c2}, 32'h0);
        idle(); rst_n = 1'b1;

        // R1: words before any sync give nothing
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            word(12'h3C0 + 12'(k)); settle(); if (pix_valid) seen = 1;
        end
        chk(!seen, "R1 no pixel before first sync", 32'(seen), 32'd0);
        idle();

        // Table walk: R2 lead-in, R3 pairing, format decode
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] m; logic [8:0] s; logic [7:0] r, g, b;
            {m, s, r, g, b} = VEC[v];
            w = pack(m, r, g, b);
            e = expect_px(m, r, g, b);
            hsync(m, s);
            seen = 0;
            for (int k = 0; k < int'(s); k++) begin
                word(12'hF0F ^ 12'(k)); settle(); if (pix_valid) seen = 1;
            end
            word(w[23:12]); settle(); if (pix_valid) seen = 1;
            chk(!seen, $sformatf("R2 lead-in quiet vec %0d", v), 32'(seen), 32'd0);
            word(w[11:0]); settle();
            chk(pix_valid, $sformatf("R3 valid after pair vec %0d", v), 32'(pix_valid), 32'd1);
            chk({pix_c0, pix_c1, pix_c2} == e, $sformatf("%s pixel vec %0d", mtag(m), v),
                {8'd0, pix_c0, pix_c1, pix_c2}, {8'd0, e});
            idle(); settle();
            chk(!pix_valid, $sformatf("R3 single pulse vec %0d", v), 32'(pix_valid), 32'd0);
        end

        // R3: idle gaps between halves do not count
        w = pack(3'd2, 8'h9C, 8'h3E, 8'h47);
        hsync(3'd2, 9'd1);
        word(12'h777); word(w[23:12]);
        seen = 0;
        for (int k = 0; k < 3; k++) begin idle(); settle(); if (pix_valid) seen = 1; end
        chk(!seen, "R3 no pulse during gap", 32'(seen), 32'd0);
        word(w[11:0]); settle();
        chk(pix_valid && {pix_c0, pix_c1, pix_c2} == 24'h9C3E47, "R3 pixel after gap",
            {7'd0, pix_valid, pix_c0, pix_c1, pix_c2}, 32'h019C3E47);
        idle();

        // R10: mode change mid-line waits for next sync
        w = pack(3'd0, 8'h11, 8'h22, 8'h0C);
        e = expect_px(3'd0, 8'h11, 8'h22, 8'h0C);
        hsync(3'd0, 9'd0);
        @(negedge clk); hs_start = 1'b0; mode_sel = 3'd4;
        word(w[23:12]); word(w[11:0]); settle();
        chk({pix_c0, pix_c1, pix_c2} == e, "R10 old mode kept in line",
            {8'd0, pix_c0, pix_c1, pix_c2}, {8'd0, e});
        hsync(3'd4, 9'd0);
        word(12'h0C8); word(12'h0D9); settle();
        chk({pix_c0, pix_c1, pix_c2} == 24'hD9C800, "R10 new mode after sync",
            {8'd0, pix_c0, pix_c1, pix_c2}, 32'h00D9C800);
        idle();

        // R11: reserved codes give no pixel
        for (int m = 5; m < 8; m++) begin
            hsync(3'(m), 9'd0);
            seen = 0;
            for (int k = 0; k < 4; k++) begin word(12'h5A5); settle(); if (pix_valid) seen = 1; end
            chk(!seen, $sformatf("R11 reserved code %0d quiet", m), 32'(seen), 32'd0);
        end
        idle();

        // R12: sync between halves restarts pairing
        w = pack(3'd2, 8'h44, 8'h55, 8'h66);
        hsync(3'd2, 9'd0);
        word(12'hBEE);
        @(negedge clk); hs_start = 1'b1; word_en = 1'b1; bus_d = 12'hDAD;
        settle();
        chk(!pix_valid, "R12 sync word gives no pixel", 32'(pix_valid), 32'd0);
        word(w[23:12]); word(w[11:0]); settle();
        chk(pix_valid && {pix_c0, pix_c1, pix_c2} == 24'h445566, "R12 realigned pixel",
            {7'd0, pix_valid, pix_c0, pix_c1, pix_c2}, 32'h01445566);
        idle();

        // R8: chroma phase alternates over back-to-back pairs
        hsync(3'd4, 9'd2);
        word(12'h000); word(12'h000);
        for (int p = 0; p < 3; p++) begin
            word(12'hF00 | 12'(8'h10 + 8'(p * 32)));
            settle();
            chk(!pix_valid, $sformatf("R3 no pulse on first half %0d", p), 32'(pix_valid), 32'd0);
            word(12'hF00 | 12'(8'h20 + 8'(p * 32)));
            settle();
            chk(pix_valid && pix_is_cr == p[0] && pix_c0 == 8'(8'h20 + p * 32) && pix_c1 == 8'(8'h10 + p * 32),
                $sformatf("R8 pair %0d", p),
                {22'd0, pix_valid, pix_is_cr, pix_c0}, {22'd0, 1'b1, p[0], 8'(8'h20 + p * 32)});
        end
        idle(); settle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule